// File: doc/BRIEF.md
# Path RDI Receive Persistence Filter

This block sits in the receive path-overhead chain and watches the remote defect indication carried in each received path status byte. Bits 3 down to 1 of that byte hold the RDI code and bit 0 is a spare bit. The spare bit is debounced together with the code. A newly seen value is adopted only after it has arrived unchanged in a selectable number of consecutive frames. This keeps single corrupted frames from disturbing the far-end defect state.

Each adoption of a new value produces a one-cycle event pulse, which an interrupt status bit can latch. A defect flag is decoded from the adopted value. A mode select picks between the full three-bit code interpretation (enhanced) and a legacy interpretation in which only bit 3 is judged. The block is fed one status byte per frame with a single-cycle strobe.

Top module: `g1_rdi_persist`

## Requirements
- R1: While and after reset, `filt_o` is 4'b0000, `upd_o` is 0 and `defect_o` is 0 until a new value is adopted.
- R2: In enhanced mode (`enh_i`=1) the candidate is `g1_i[3:0]`: RDI code in bits 3..1, spare in bit 0. Bits 7..4 of `g1_i` have no effect on any output.
- R3: `len_sel_i` picks the persistence length: 2'b00=3, 2'b01=5, 2'b10=10, 2'b11=16 frames. A candidate different from `filt_o` is adopted on exactly the Nth consecutive strobed frame that carries it, and not earlier.
- R4: A strobed frame whose candidate differs from the previous strobed frame's candidate restarts the run at one.
- R5: `upd_o` is high for exactly one cycle, in the cycle after the strobed frame that adopts a new value. This is the same cycle in which `filt_o` takes the new value.
- R6: Cycles with `frame_vld_i`=0 neither advance nor restart a run, and do not change `filt_o`.
- R7: In non-enhanced mode (`enh_i`=0) the candidate is {`g1_i[3]`, 3'b000}. Bits 2..0 of the byte are ignored.
- R8: In enhanced mode `defect_o` is 1 exactly when `filt_o[3:1]` is neither 3'b000 nor 3'b001.
- R9: In non-enhanced mode `defect_o` equals `filt_o[3]`.
- R10: A candidate equal to the current `filt_o` never raises `upd_o`, however long it persists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| g1_i | input | 8 | Received path status byte |
| frame_vld_i | input | 1 | One-cycle strobe marking a valid byte in `g1_i` |
| len_sel_i | input | 2 | Persistence length select (3/5/10/16 frames) |
| enh_i | input | 1 | 1 = enhanced code, 0 = bit 3 only |
| filt_o | output | 4 | Adopted (filtered) RDI code and spare bit |
| defect_o | output | 1 | Far-end defect indication decoded from `filt_o` |
| upd_o | output | 1 | One-cycle pulse on every change of `filt_o` |

## Verification
The bench builds the block with the default lengths 3, 5, 10 and 16, so every length select is exercised. All four lengths are swept against all sixteen candidate nibbles in both modes, with the upper byte bits scrambled. An independent frame-level model predicts the output after every strobe. Further targeted runs cover an interrupted run one frame short of the length, long idle gaps between strobes, and a persisting value that already equals the adopted one.

// File: rtl/g1_rdi_pkg.sv
// Package: shared types and helpers for the path RDI persistence filter.
// Assumes the RDI field plus spare bit is always four bits wide.
package g1_rdi_pkg;

    localparam int unsigned NIB_W = 4;

    typedef logic [NIB_W-1:0] rdi_nib_t;

    typedef enum logic [1:0] {
        LSEL_SHORT = 2'b00,
        LSEL_MID   = 2'b01,
        LSEL_LONG  = 2'b10,
        LSEL_MAX   = 2'b11
    } len_sel_e;

    // Largest of four lengths; used to size the run counter.
    function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                            input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/rdi_cand_sel.sv
// Module: builds the per-frame candidate nibble from the status byte.
// Enhanced mode keeps bits 3..0; legacy mode keeps bit 3 and zeroes the rest.
// Purely combinational; assumes g1 is only meaningful under the frame strobe.
module rdi_cand_sel
    import g1_rdi_pkg::*;
(
    input  logic [7:0] g1,
    input  logic       enh,
    output rdi_nib_t   cand
);

    // Select candidate bits according to interpretation mode.
    always_comb begin
        if (enh) cand = g1[NIB_W-1:0];
        else     cand = {g1[3], 3'b000};
    end

endmodule

// File: rtl/rdi_len_sel.sv
// Module: maps the 2-bit length select onto a frame count.
// Assumes every length parameter fits in CNT_W bits and is at least 2.
module rdi_len_sel #(
    parameter int unsigned LEN_A = 3,
    parameter int unsigned LEN_B = 5,
    parameter int unsigned LEN_C = 10,
    parameter int unsigned LEN_D = 16,
    parameter int unsigned CNT_W = 5
) (
    input  logic [1:0]       sel,
    output logic [CNT_W-1:0] len
);

    localparam int unsigned N_SEL = 4;
    localparam int unsigned LENS [N_SEL] = '{LEN_A, LEN_B, LEN_C, LEN_D};

    logic [CNT_W-1:0] tbl [N_SEL];

    genvar gi;
    generate
        for (gi = 0; gi < N_SEL; gi++) begin : g_tbl
            assign tbl[gi] = CNT_W'(LENS[gi]);
        end
    endgenerate

    // Look up the selected length.
    always_comb len = tbl[sel];

endmodule

// File: rtl/rdi_persist_ctr.sv
// Module: counts consecutive strobed frames carrying the same candidate.
// A changed candidate restarts the run at one; the count saturates at CNT_MAX.
// Idle cycles (no strobe) hold both the run and the remembered candidate.
module rdi_persist_ctr
    import g1_rdi_pkg::*;
#(
    parameter int unsigned CNT_W   = 5,
    parameter int unsigned CNT_MAX = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_vld,
    input  rdi_nib_t         cand,
    input  logic [CNT_W-1:0] len,
    output logic             hit
);

    localparam logic [CNT_W-1:0] CMAX = CNT_W'(CNT_MAX);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    rdi_nib_t         prev_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    // Next run length given this frame's candidate.
    always_comb begin
        if (cand != prev_q)    cnt_d = ONE;
        else if (cnt_q < CMAX) cnt_d = cnt_q + ONE;
        else                   cnt_d = cnt_q;
    end

    // Register run length and last candidate on each strobed frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            cnt_q  <= '0;
        end else if (frame_vld) begin
            prev_q <= cand;
            cnt_q  <= cnt_d;
        end
    end

    // Persistence reached on this frame.
    always_comb hit = frame_vld && (cnt_d >= len);

endmodule

// File: rtl/rdi_accept.sv
// Module: holds the adopted value and emits the one-cycle change pulse.
// Assumes hit is only asserted together with the frame strobe.
module rdi_accept
    import g1_rdi_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     hit,
    input  rdi_nib_t cand,
    output rdi_nib_t filt,
    output logic     upd
);

    logic take;

    // Adopt only values that differ from the held one.
    always_comb take = hit && (cand != filt);

    // Update adopted value and event pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt <= '0;
            upd  <= 1'b0;
        end else begin
            upd <= take;
            if (take) filt <= cand;
        end
    end

endmodule

// File: rtl/rdi_defect_dec.sv
// Module: decodes the far-end defect flag from the adopted value.
// Enhanced: codes 000 and 001 in bits 3..1 mean no defect; legacy: bit 3 only.
module rdi_defect_dec
    import g1_rdi_pkg::*;
(
    input  rdi_nib_t filt,
    input  logic     enh,
    output logic     defect
);

    // Mode-dependent defect decode.
    always_comb begin
        if (enh) defect = (filt[3:1] != 3'b000) && (filt[3:1] != 3'b001);
        else     defect = filt[3];
    end

endmodule

// File: rtl/g1_rdi_persist.sv
// Module: top of the path RDI receive persistence filter.
// Chains candidate selection, run counting, adoption and defect decode.
// Assumes one strobed byte per frame and quasi-static mode/length selects.
module g1_rdi_persist
    import g1_rdi_pkg::*;
#(
    parameter int unsigned LEN_A = 3,
    parameter int unsigned LEN_B = 5,
    parameter int unsigned LEN_C = 10,
    parameter int unsigned LEN_D = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] g1_i,
    input  logic       frame_vld_i,
    input  logic [1:0] len_sel_i,
    input  logic       enh_i,
    output logic [3:0] filt_o,
    output logic       defect_o,
    output logic       upd_o
);

    localparam int unsigned LEN_MAX = max_of4(LEN_A, LEN_B, LEN_C, LEN_D);
    localparam int unsigned CNT_W   = $clog2(LEN_MAX + 1);

    rdi_nib_t         cand;
    rdi_nib_t         filt;
    logic [CNT_W-1:0] len;
    logic             hit;

    rdi_cand_sel u_cand (
        .g1   (g1_i),
        .enh  (enh_i),
        .cand (cand)
    );

    rdi_len_sel #(
        .LEN_A (LEN_A), .LEN_B (LEN_B), .LEN_C (LEN_C), .LEN_D (LEN_D),
        .CNT_W (CNT_W)
    ) u_len (
        .sel (len_sel_i),
        .len (len)
    );

    rdi_persist_ctr #(
        .CNT_W   (CNT_W),
        .CNT_MAX (LEN_MAX)
    ) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_vld (frame_vld_i),
        .cand      (cand),
        .len       (len),
        .hit       (hit)
    );

    rdi_accept u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .cand  (cand),
        .filt  (filt),
        .upd   (upd_o)
    );

    rdi_defect_dec u_dec (
        .filt   (filt),
        .enh    (enh_i),
        .defect (defect_o)
    );

    // Drive adopted value to the port.
    always_comb filt_o = filt;

endmodule

// File: rtl/g1_rdi_persist_chk.sv
// Checker: temporal properties of the persistence filter, bound to the top.
module g1_rdi_persist_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_vld_i,
    input logic [3:0] filt_o,
    input logic       defect_o,
    input logic       upd_o
);

    // R5: a pulse always accompanies a real change of the adopted value
    p_upd_changes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> (filt_o != $past(filt_o)));

    // R5: every change of the adopted value is announced
    p_change_flagged_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_o != $past(filt_o)) |-> upd_o);

    // R5: pulse lasts a single cycle
    p_upd_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |=> !upd_o);

    // R6: without a strobe the adopted value holds
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_vld_i |=> $stable(filt_o));

    // R6: a pulse follows only a strobed frame
    p_upd_after_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> $past(frame_vld_i));

    // R8: a defect implies a nonzero adopted value
    p_defect_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        defect_o |-> (filt_o != 4'b0000));

endmodule

bind g1_rdi_persist g1_rdi_persist_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_vld_i (frame_vld_i),
    .filt_o      (filt_o),
    .defect_o    (defect_o),
    .upd_o       (upd_o)
);

// File: tb/sim_g1_rdi_persist.sv
// Bench: sweeps all length selects, both modes and all candidate nibbles
// against a frame-level model computed from the requirements.
module sim_g1_rdi_persist;

    localparam int CLK_PER = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] g1_i = 8'h00;
    logic       frame_vld_i = 1'b0;
    logic [1:0] len_sel_i = 2'b00;
    logic       enh_i = 1'b1;
    logic [3:0] filt_o;
    logic       defect_o;
    logic       upd_o;

    int checks = 0;
    int errors = 0;

    // model state
    logic [3:0] m_prev = 4'h0;
    int         m_cnt  = 0;
    logic [3:0] m_filt = 4'h0;
    logic       m_upd  = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    g1_rdi_persist u0 (
        .clk(clk), .rst_n(rst_n), .g1_i(g1_i), .frame_vld_i(frame_vld_i),
        .len_sel_i(len_sel_i), .enh_i(enh_i), .filt_o(filt_o),
        .defect_o(defect_o), .upd_o(upd_o)
    );

    function automatic int len_of(input logic [1:0] s);
        case (s)
            2'b00:   return 3;
            2'b01:   return 5;
            2'b10:   return 10;
            default: return 16;
        endcase
    endfunction

    function automatic logic exp_defect(input logic [3:0] f, input logic e);
        if (e) return f[3:1] > 3'd1;
        return f[3];
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Compare all outputs with the model (tags name the rule under test).
    task automatic chk_all(input string tag);
        chk({tag, " filt"}, filt_o, m_filt);
        chk({tag, " upd"}, upd_o, m_upd);
        chk({tag, " defect R8 R9"}, defect_o, exp_defect(m_filt, enh_i));
    endtask

    // One strobed frame, then sample one cycle later (after the edge).
    task automatic frame(input logic [7:0] b);
        logic [3:0] c;
        @(negedge clk);
        g1_i = b;
        frame_vld_i = 1'b1;
        c = enh_i ? b[3:0] : {b[3], 3'b000};
        if (c != m_prev) begin m_prev = c; m_cnt = 1; end
        else if (m_cnt < 16) m_cnt++;
        m_upd = (m_cnt >= len_of(len_sel_i)) && (c != m_filt);
        if (m_upd) m_filt = c;
        @(negedge clk);
        frame_vld_i = 1'b0;
        g1_i = ~b;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        m_upd = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 filt", filt_o, 0);
        chk("R1 upd", upd_o, 0);
        chk("R1 defect", defect_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 filt after release", filt_o, 0);

        // R2 R3 R5 R7 sweep: every length, mode and nibble
        for (int md = 1; md >= 0; md--) begin
            for (int s = 0; s < 4; s++) begin
                enh_i = md[0];
                len_sel_i = s[1:0];
                for (int v = 0; v < 16; v++) begin
                    logic [7:0] b;
                    int n;
                    n = len_of(s[1:0]);
                    for (int k = 0; k < n; k++) begin
                        b = {4'(v * 5 + k * 3), 4'(v)};
                        frame(b);
                        if (k < n - 1) chk_all(md ? "R2 R3 pre" : "R7 R3 pre");
                        else           chk_all(md ? "R2 R3 R5 accept" : "R7 R3 R5 accept");
                    end
                    @(negedge clk);
                    m_upd = 1'b0;
                    chk("R5 pulse one cycle", upd_o, 0);
                end
            end
        end

        // R4: run broken one frame short, then restarted
        enh_i = 1'b1;
        len_sel_i = 2'b01;
        for (int k = 0; k < 4; k++) frame(8'h0C);
        frame(8'h0A);
        for (int k = 0; k < 4; k++) begin
            frame(8'h0C);
            chk_all("R4 restart");
        end
        chk("R4 not adopted", filt_o == 4'hC, 0);
        frame(8'h0C);
        chk_all("R4 adopt after full run");
        chk("R4 value", filt_o, 4'hC);

        // R6: long gaps between strobes neither restart nor advance
        len_sel_i = 2'b00;
        frame(8'hF6);
        idle(20);
        chk_all("R6 gap hold");
        frame(8'hA6);
        idle(7);
        chk_all("R6 gap hold");
        frame(8'h56);
        chk_all("R6 adopt across gaps");
        chk("R6 value", filt_o, 4'h6);
        chk("R8 defect code 011", defect_o, 1);

        // R10: persisting equal value never pulses
        for (int k = 0; k < 20; k++) begin
            frame(8'h36);
            chk("R10 no pulse", upd_o, 0);
        end

        // R8: code 001 is not a defect
        for (int k = 0; k < 3; k++) frame(8'h03);
        chk("R8 code 001", defect_o, 0);
        chk_all("R8 R5 adopt 3");

        // R9: legacy mode judges bit 3 only
        enh_i = 1'b0;
        @(negedge clk);
        chk("R9 defect legacy bit3=0", defect_o, 0);
        for (int k = 0; k < 3; k++) frame(8'h08);
        chk_all("R9 R7 legacy adopt");
        chk("R9 defect legacy bit3=1", defect_o, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule